// File: doc/BRIEF.md
# I2C Mode Control Register

This block is the mode-control slice of an I2C controller. It holds three software-visible control bits: master select, transmit select and acknowledge enable. It also holds one read-only status bit that reports the acknowledge received from the far end. Software reads and writes all of these through a single register on a simple strobe-based CPU bus. Software uses this register to take or give up the bus master role, to choose the transfer direction, and to decide whether a negative acknowledge should stop a continuous transfer.

The bus engine can also change the master and transmit bits without software. If arbitration is lost while the block is master, both bits fall. If a slave address match arrives with a read request, the transmit bit rises. After such a change, software must first read the register before it can write the opposite value back. A write that conflicts with a hardware-forced value is dropped until a read has returned that value. This stops a read-modify-write from software from undoing a hardware decision that software has not yet seen.

When acknowledge checking is on, the block latches the received acknowledge bit at each byte end. A negative acknowledge raises a halt output, which the bus engine uses to stop continuous transfer. The halt stays up until software writes the register again.

Top module: `i2c_mode_ctrl`

## Requirements
- R1: After reset every field reads 0. The register layout is: bit 0 acknowledge enable, bit 1 transmit select, bit 2 master select, bit 3 acknowledge status (read-only, writes to it are ignored). The outputs mst_o, trs_o, ack_en_o, ack_stat_o and halt_o are all 0.
- R2: A register write updates bits 0 to 2 at the next clock edge when no hardware change is pending. The master bit rises only through a write.
- R3: An arbitration-loss pulse while mst_o is 1 clears both master and transmit at the next edge. The same pulse while mst_o is 0 has no effect.
- R4: After hardware has changed master or transmit, a write of the opposite value to that bit is dropped. The write takes effect only once software has read the register. Writes to the other bits still apply.
- R5: An address-match pulse with the received R/W bit at 1 sets transmit at the next edge. With R/W at 0 the pulse leaves transmit unchanged.
- R6: When a hardware event and a register write fall in the same cycle, the hardware event decides the affected bits.
- R7: While acknowledge enable is 0, the acknowledge status is 0 from the next edge on. A byte end does not raise the halt.
- R8: While acknowledge enable is 1, a byte-end pulse latches the received acknowledge bit into the status bit. A received 1 raises halt_o.
- R9: halt_o stays at 1 through idle cycles and reads. Only the next register write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 4 | Write data |
| reg_rdata_o | output | 4 | Read data, current register contents |
| arb_lost_i | input | 1 | Arbitration lost pulse from bus engine |
| addr_match_i | input | 1 | Slave address matched pulse |
| rw_bit_i | input | 1 | Received R/W bit, valid with addr_match_i |
| byte_done_i | input | 1 | Byte end pulse |
| ack_bit_i | input | 1 | Received acknowledge bit, valid with byte_done_i |
| mst_o | output | 1 | Master select |
| trs_o | output | 1 | Transmit select |
| ack_en_o | output | 1 | Acknowledge enable |
| ack_stat_o | output | 1 | Latched acknowledge status |
| halt_o | output | 1 | Halt continuous transfer |

## Verification
The assertions check the hardware paths on every cycle. These are the clearing on arbitration loss, the setting of transmit on a read-direction address match, the latching of the acknowledge and the raising of the halt, the holding of the halt, and the zero status while checking is off. The read-before-write interlock depends on a hidden pending flag, so only the bench scenarios can show it. They do this by issuing conflicting writes before and after a read and comparing the read data. The same holds for the priority of a hardware event over a write in the same cycle.

// File: rtl/i2c_mode_pkg.sv
package i2c_mode_pkg;
  localparam int unsigned REG_W    = 4;
  localparam int unsigned ACKE_POS = 0;
  localparam int unsigned TRS_POS  = 1;
  localparam int unsigned MST_POS  = 2;
  localparam int unsigned ACKS_POS = 3;
  localparam int unsigned NUM_HW   = 2;  // bits hardware may force
endpackage

// File: rtl/i2c_forced_bit.sv
module i2c_forced_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hw_set_i,
  input  logic hw_clr_i,
  input  logic sw_we_i,
  input  logic sw_wdata_i,
  input  logic sw_re_i,
  output logic bit_o
);
  logic bit_q, pend_q;
  logic conflict;

  // while pending, bit_q holds the forced value
  assign conflict = pend_q & (sw_wdata_i != bit_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (hw_clr_i) begin
      bit_q  <= 1'b0;
      pend_q <= 1'b1;
    end else if (hw_set_i) begin
      bit_q  <= 1'b1;
      pend_q <= 1'b1;
    end else begin
      if (sw_we_i && !conflict) bit_q <= sw_wdata_i;
      if (sw_re_i) pend_q <= 1'b0;
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/i2c_ack_gate.sv
module i2c_ack_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic wdata_en_i,
  input  logic byte_done_i,
  input  logic ack_bit_i,
  output logic ack_en_o,
  output logic ack_stat_o,
  output logic halt_o
);
  logic en_q, stat_q, halt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      stat_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      if (we_i) en_q <= wdata_en_i;
      if (!en_q)            stat_q <= 1'b0;
      else if (byte_done_i) stat_q <= ack_bit_i;
      // a nack at byte end outranks the clearing write
      if (en_q && byte_done_i && ack_bit_i) halt_q <= 1'b1;
      else if (we_i)                        halt_q <= 1'b0;
    end
  end

  assign ack_en_o   = en_q;
  assign ack_stat_o = stat_q;
  assign halt_o     = halt_q;
endmodule

// File: rtl/i2c_mode_ctrl.sv
module i2c_mode_ctrl
  import i2c_mode_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             arb_lost_i,
  input  logic             addr_match_i,
  input  logic             rw_bit_i,
  input  logic             byte_done_i,
  input  logic             ack_bit_i,
  output logic             mst_o,
  output logic             trs_o,
  output logic             ack_en_o,
  output logic             ack_stat_o,
  output logic             halt_o
);
  localparam int unsigned HW_POS [NUM_HW] = '{TRS_POS, MST_POS};

  logic              arb_hit;
  logic [NUM_HW-1:0] hw_set, hw_clr, hw_bit;

  assign arb_hit = arb_lost_i & hw_bit[1];
  assign hw_set  = {1'b0, addr_match_i & rw_bit_i};
  assign hw_clr  = {arb_hit, arb_hit};

  for (genvar i = 0; i < NUM_HW; i++) begin : g_hw_bit
    i2c_forced_bit u_bit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .hw_set_i   (hw_set[i]),
      .hw_clr_i   (hw_clr[i]),
      .sw_we_i    (reg_we_i),
      .sw_wdata_i (reg_wdata_i[HW_POS[i]]),
      .sw_re_i    (reg_re_i),
      .bit_o      (hw_bit[i])
    );
  end

  i2c_ack_gate u_ack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .wdata_en_i  (reg_wdata_i[ACKE_POS]),
    .byte_done_i (byte_done_i),
    .ack_bit_i   (ack_bit_i),
    .ack_en_o    (ack_en_o),
    .ack_stat_o  (ack_stat_o),
    .halt_o      (halt_o)
  );

  assign trs_o = hw_bit[0];
  assign mst_o = hw_bit[1];

  always_comb begin
    reg_rdata_o           = '0;
    reg_rdata_o[ACKE_POS] = ack_en_o;
    reg_rdata_o[TRS_POS]  = trs_o;
    reg_rdata_o[MST_POS]  = mst_o;
    reg_rdata_o[ACKS_POS] = ack_stat_o;
  end
endmodule

// File: rtl/i2c_mode_ctrl_chk.sv
module i2c_mode_ctrl_chk
  import i2c_mode_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [REG_W-1:0] reg_wdata_i,
  input logic             arb_lost_i,
  input logic             addr_match_i,
  input logic             rw_bit_i,
  input logic             byte_done_i,
  input logic             ack_bit_i,
  input logic             mst_o,
  input logic             trs_o,
  input logic             ack_en_o,
  input logic             ack_stat_o,
  input logic             halt_o
);
  p_mst_sw_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mst_o && !reg_we_i |=> !mst_o);

  p_arb_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_i && mst_o |=> !mst_o && !trs_o);

  p_addr_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_match_i && rw_bit_i && !(arb_lost_i && mst_o) |=> trs_o);

  p_ack_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_en_o |=> !ack_stat_o);

  p_ack_latch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_i && ack_en_o |=> ack_stat_o == $past(ack_bit_i));

  p_halt_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_i && ack_en_o && ack_bit_i |=> halt_o);

  p_halt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && !reg_we_i |=> halt_o);

  p_halt_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && !(byte_done_i && ack_en_o && ack_bit_i) |=> !halt_o);

  logic unused_ok;
  assign unused_ok = ^reg_wdata_i;
endmodule

bind i2c_mode_ctrl i2c_mode_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_wdata_i  (reg_wdata_i),
  .arb_lost_i   (arb_lost_i),
  .addr_match_i (addr_match_i),
  .rw_bit_i     (rw_bit_i),
  .byte_done_i  (byte_done_i),
  .ack_bit_i    (ack_bit_i),
  .mst_o        (mst_o),
  .trs_o        (trs_o),
  .ack_en_o     (ack_en_o),
  .ack_stat_o   (ack_stat_o),
  .halt_o       (halt_o)
);

// File: tb/tb_i2c_mode_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_mode_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [3:0] reg_wdata_i = '0;
  logic [3:0] reg_rdata_o;
  logic       arb_lost_i = 1'b0, addr_match_i = 1'b0, rw_bit_i = 1'b0;
  logic       byte_done_i = 1'b0, ack_bit_i = 1'b0;
  logic       mst_o, trs_o, ack_en_o, ack_stat_o, halt_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk_i = ~clk_i;

  i2c_mode_ctrl dut (.*);

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // monitor: compares read data while the read strobe is high
  always @(negedge clk_i) begin
    if (reg_re_i) begin
      if (exp_q.size() == 0) chk("read without expectation", reg_rdata_o, 4'hx);
      else chk(tag_q.pop_front(), reg_rdata_o, exp_q.pop_front());
    end
  end

  task automatic bus_wr(logic [3:0] v);
    @(posedge clk_i); #1 reg_we_i = 1'b1; reg_wdata_i = v;
    @(posedge clk_i); #1 reg_we_i = 1'b0;
  endtask

  task automatic bus_rd(logic [3:0] exp, string tag);
    @(posedge clk_i); #1 reg_re_i = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk_i); #1 reg_re_i = 1'b0;
  endtask

  task automatic arb_pulse();
    @(posedge clk_i); #1 arb_lost_i = 1'b1;
    @(posedge clk_i); #1 arb_lost_i = 1'b0;
  endtask

  task automatic addr_pulse(logic rw);
    @(posedge clk_i); #1 addr_match_i = 1'b1; rw_bit_i = rw;
    @(posedge clk_i); #1 addr_match_i = 1'b0; rw_bit_i = 1'b0;
  endtask

  task automatic byte_pulse(logic ack);
    @(posedge clk_i); #1 byte_done_i = 1'b1; ack_bit_i = ack;
    @(posedge clk_i); #1 byte_done_i = 1'b0; ack_bit_i = 1'b0;
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) chk("R1 unserved reads", 4'(exp_q.size()), 4'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    chk("R1 reset outputs", {mst_o, trs_o, ack_en_o, halt_o}, 4'b0000);
    bus_rd(4'b0000, "R1 reset read");

    bus_wr(4'b1111);                       // status bit not writable
    bus_rd(4'b0111, "R2 write all");

    arb_pulse();
    chk("R3 arb clears master", {2'b00, mst_o, trs_o}, 4'b0000);
    bus_wr(4'b0111);                       // no read yet: mst/trs dropped
    bus_rd(4'b0001, "R4 write dropped before read");
    bus_wr(4'b0111);
    bus_rd(4'b0111, "R4 write accepted after read");

    bus_wr(4'b0010);
    bus_rd(4'b0010, "R2 plain write");
    arb_pulse();
    bus_rd(4'b0010, "R3 arb ignored when not master");

    bus_wr(4'b0000);
    addr_pulse(1'b1);
    chk("R5 read request sets trs", {3'b000, trs_o}, 4'b0001);
    bus_wr(4'b0000);
    bus_rd(4'b0010, "R4 trs clear dropped before read");
    bus_wr(4'b0000);
    bus_rd(4'b0000, "R4 trs clear after read");
    addr_pulse(1'b0);
    bus_rd(4'b0000, "R5 write request leaves trs");

    bus_wr(4'b0111);
    bus_rd(4'b0111, "R2 master set");
    @(posedge clk_i); #1 arb_lost_i = 1'b1; reg_we_i = 1'b1; reg_wdata_i = 4'b0111;
    @(posedge clk_i); #1 arb_lost_i = 1'b0; reg_we_i = 1'b0;
    bus_rd(4'b0001, "R6 hardware beats write");

    byte_pulse(1'b1);
    chk("R8 nack raises halt", {3'b000, halt_o}, 4'b0001);
    @(posedge clk_i); #1;
    chk("R9 halt held idle", {3'b000, halt_o}, 4'b0001);
    bus_rd(4'b1001, "R8 status latched");
    chk("R9 halt held over read", {3'b000, halt_o}, 4'b0001);
    bus_wr(4'b0001);
    chk("R9 write clears halt", {3'b000, halt_o}, 4'b0000);
    byte_pulse(1'b0);
    chk("R8 ack keeps halt low", {2'b00, ack_stat_o, halt_o}, 4'b0000);
    bus_rd(4'b0001, "R8 status follows ack");

    byte_pulse(1'b1);
    bus_wr(4'b0000);
    byte_pulse(1'b1);
    chk("R7 disabled ack ignored", {2'b00, ack_stat_o, halt_o}, 4'b0000);
    bus_rd(4'b0000, "R7 status reads zero");

    repeat (2) @(posedge clk_i);
    done = 1'b1;
    finish_run();
  end
endmodule